// File: doc/BRIEF.md
# DMA Control-Port Register Block

This block is the control-register section of a four-channel DMA controller. It decodes host writes and reads to the upper eight control indexes (0x8 to 0xF). It keeps a command register, a per-channel mask, an 8-bit status register and one mode byte per channel. It also takes per-channel external request assert and release strobes and per-channel terminal-count pulses. The address and count datapath and the bus transfer engine live elsewhere.

Each cycle the block presents a registered service-request vector. A channel's bit in that vector is set when the channel is unmasked and its request status bit is set. The transfer engine takes channels from 0 up to 3. The block also gives a one-cycle pulse that tells the datapath to clear its low/high byte pointer. The mode bytes are exported so that the datapath can read the operation, auto-init, decrement and mode-select fields.

Status layout: bits 3:0 hold the terminal-count flags for channels 3..0, and bits 7:4 hold the request flags for channels 3..0. Bit 4+n belongs to channel n.

Top module: `dmac_ctl_top`

## Requirements
- R1: After hardware reset (rst_n low at a clock edge) the mask is 4'b1111, status is 0, the command is 0, every mode byte is 0, svc_req is 0 and clr_ptr is 0.
- R2: A write to index 0x8 loads the command register only if the data is 0x00 or 0x04. Any other value, meaning a value with a bit set outside bit 2, leaves the register unchanged.
- R3: A write to index 0x9 selects channel n = wdata[1:0]. It sets status bit 4+n to wdata[2] and always clears status bit n.
- R4: A write to index 0xA sets mask bit wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0. Other mask bits do not change.
- R5: A write to index 0xB stores all of wdata in the mode byte of channel wdata[1:0]. Mode byte n appears on mode_flat[8n+7:8n]. Other channels' bytes do not change.
- R6: A write to index 0xC or 0xD drives clr_ptr high for exactly the one cycle after that write's clock edge. An index 0xC write changes no register.
- R7: A write to index 0xD sets the mask to all ones and clears status and command. It takes priority over any same-cycle request or terminal-count event. It leaves mode bytes unchanged.
- R8: A write to index 0xE clears all mask bits. A write to index 0xF loads the mask from wdata[3:0].
- R9: With rd_en high, rdata shows status for index 0x8 and {4'b0, mask} for index 0xF. It shows 0 for every other index, and it is 0 whenever rd_en is low. A status read clears status bits 3:0 at the clock edge.
- R10: dreq_set[n] sets status bit 4+n and dreq_clr[n] clears it. These events act after a same-cycle index 0x9 write. When both strobes are high for a channel, the set wins.
- R11: tc_in[n] sets status bit n. It wins over a same-cycle status-read clear or an index 0x9 clear.
- R12: svc_req is registered. After each clock edge it equals the new (~mask & status[7:4]), so a mask or request change shows on svc_req in the cycle after the write or strobe.
- R13: Writes to indexes 0x0 to 0x7 change no state in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| idx | input | 4 | Register index within the controller |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| dreq_set | input | 4 | Per-channel external request assert |
| dreq_clr | input | 4 | Per-channel external request release |
| tc_in | input | 4 | Per-channel terminal-count pulse from the datapath |
| svc_req | output | 4 | Registered per-channel service request |
| clr_ptr | output | 1 | One-cycle byte-pointer clear pulse |
| cmd_q | output | 8 | Current command register |
| mode_flat | output | 32 | Mode bytes, channel n at bits 8n+7:8n |

## Verification
The assertions assume that wr_en and rd_en are known whenever rst_n is high. They also assume that request and terminal-count strobes are one-cycle events that the host does not need to see acknowledged. Nothing is assumed about the order of events within a cycle. The bench drives inputs only on falling edges and returns every strobe to zero after one edge. It also covers the same-cycle collisions the requirements rank: set against release, terminal count against a status read, and master reset against a request.

// File: rtl/dmac_ctl_pkg.sv
// Package: shared index codes and decoded write strobes for the DMA
// control-port block. Assumes a 4-bit controller index in which the upper
// half (0x8..0xF) addresses control registers.
package dmac_ctl_pkg;

    localparam logic [3:0] IDX_CMD    = 4'h8;
    localparam logic [3:0] IDX_REQ    = 4'h9;
    localparam logic [3:0] IDX_SMASK  = 4'hA;
    localparam logic [3:0] IDX_MODE   = 4'hB;
    localparam logic [3:0] IDX_PTRCLR = 4'hC;
    localparam logic [3:0] IDX_MRST   = 4'hD;
    localparam logic [3:0] IDX_MCLR   = 4'hE;
    localparam logic [3:0] IDX_MALL   = 4'hF;

    // Only bit 2 of the command byte is accepted.
    localparam logic [7:0] CMD_ALLOWED = 8'h04;
    // Bit of wdata that carries set/clear for request and single-mask writes.
    localparam int FLAG_BIT = 2;

    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic ptrclr;
        logic mrst;
        logic mclr;
        logic mall;
    } ctl_wr_t;

endpackage

// File: rtl/dmac_ctl_decode.sv
// Module: dmac_ctl_decode
// Turns a host write or read at a control index into one-hot strobes.
// Assumes wr_en and rd_en are single-cycle qualified strobes.
module dmac_ctl_decode
    import dmac_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] idx,
    output ctl_wr_t    wr_stb,
    output logic       rd_status,
    output logic       rd_mask
);

    // Write decode: one strobe per control index.
    always_comb begin
        wr_stb        = '0;
        wr_stb.cmd    = wr_en && (idx == IDX_CMD);
        wr_stb.req    = wr_en && (idx == IDX_REQ);
        wr_stb.smask  = wr_en && (idx == IDX_SMASK);
        wr_stb.mode   = wr_en && (idx == IDX_MODE);
        wr_stb.ptrclr = wr_en && (idx == IDX_PTRCLR);
        wr_stb.mrst   = wr_en && (idx == IDX_MRST);
        wr_stb.mclr   = wr_en && (idx == IDX_MCLR);
        wr_stb.mall   = wr_en && (idx == IDX_MALL);
    end

    // Read decode: only status and mask are readable.
    always_comb begin
        rd_status = rd_en && (idx == IDX_CMD);
        rd_mask   = rd_en && (idx == IDX_MALL);
    end

    // R13: a write at a low index raises no strobe; at most one strobe at a time.
    assert_onehot_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb) && ((wr_en && !idx[3]) -> (wr_stb == '0)));

endmodule

// File: rtl/dmac_ctl_mask.sv
// Module: dmac_ctl_mask
// Holds the per-channel mask. It exposes the registered value and the
// next-state value, which the top uses to register the service vector.
// Assumes at most one of the write strobes is high in a cycle.
module dmac_ctl_mask #(
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              mclr,
    input  logic              mall,
    input  logic              smask,
    input  logic [SEL_W-1:0]  sel,
    input  logic              flag,
    input  logic [NUM_CH-1:0] all_val,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] mask_d
);

    // Next mask from the single, clear-all, load-all and master-reset writes.
    always_comb begin
        mask_d = mask_q;
        if (mrst)
            mask_d = '1;
        else if (mclr)
            mask_d = '0;
        else if (mall)
            mask_d = all_val;
        else if (smask)
            mask_d[sel] = flag;
    end

    // Mask register; all channels masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else
            mask_q <= mask_d;
    end

    // R7: master reset leaves every channel masked.
    assert_mrst_masks_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (mask_q == '1));

    // R4: a single-mask write touches only the selected bit.
    assert_single_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smask && !mrst) |=> (mask_q[$past(sel)] == $past(flag)));

endmodule

// File: rtl/dmac_ctl_status.sv
// Module: dmac_ctl_status
// Holds terminal-count flags (low half) and request flags (high half).
// Event order within a cycle: request write, then external release/assert,
// then terminal-count set; master reset overrides everything.
// Assumes strobes are one cycle wide.
module dmac_ctl_status #(
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH),
    localparam int ST_W  = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              req_wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic              flag,
    input  logic              rd_clr,
    input  logic [NUM_CH-1:0] dreq_set,
    input  logic [NUM_CH-1:0] dreq_clr,
    input  logic [NUM_CH-1:0] tc_in,
    output logic [ST_W-1:0]   stat_q,
    output logic [NUM_CH-1:0] req_d
);

    logic [NUM_CH-1:0] tc_d;

    // Next status: apply events in their fixed order.
    always_comb begin
        req_d = stat_q[ST_W-1:NUM_CH];
        tc_d  = stat_q[NUM_CH-1:0];
        if (req_wr) begin
            req_d[sel] = flag;
            tc_d[sel]  = 1'b0;
        end
        if (rd_clr)
            tc_d = '0;
        req_d = (req_d & ~dreq_clr) | dreq_set;
        tc_d  = tc_d | tc_in;
        if (mrst) begin
            req_d = '0;
            tc_d  = '0;
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= {req_d, tc_d};
    end

    // R11: a terminal-count pulse is recorded unless master reset wins.
    assert_tc_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_in != '0) && !mrst) |=> ((stat_q[NUM_CH-1:0] & $past(tc_in)) == $past(tc_in)));

    // R10: an external assert is recorded unless master reset wins.
    assert_dreq_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dreq_set != '0) && !mrst) |=> ((stat_q[ST_W-1:NUM_CH] & $past(dreq_set)) == $past(dreq_set)));

    // R7: master reset empties status.
    assert_mrst_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (stat_q == '0));

endmodule

// File: rtl/dmac_ctl_top.sv
// Module: dmac_ctl_top
// Control-port section of a four-channel DMA controller: command, mask,
// status and mode registers, host read mux, byte-pointer clear pulse and a
// registered service-request vector. Assumes NUM_CH * 2 <= DATA_W.
module dmac_ctl_top
    import dmac_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(NUM_CH),
    localparam int ST_W  = 2 * NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [3:0]               idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH-1:0]        dreq_set,
    input  logic [NUM_CH-1:0]        dreq_clr,
    input  logic [NUM_CH-1:0]        tc_in,
    output logic [NUM_CH-1:0]        svc_req,
    output logic                     clr_ptr,
    output logic [DATA_W-1:0]        cmd_q,
    output logic [NUM_CH*DATA_W-1:0] mode_flat
);

    ctl_wr_t            wr_stb;
    logic               rd_status;
    logic               rd_mask;
    logic [NUM_CH-1:0]  mask_q;
    logic [NUM_CH-1:0]  mask_d;
    logic [ST_W-1:0]    stat_q;
    logic [NUM_CH-1:0]  req_d;
    logic [SEL_W-1:0]   sel;
    logic               flag;
    logic               cmd_ok;

    assign sel  = wdata[SEL_W-1:0];
    assign flag = wdata[FLAG_BIT];

    dmac_ctl_decode i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .idx       (idx),
        .wr_stb    (wr_stb),
        .rd_status (rd_status),
        .rd_mask   (rd_mask)
    );

    dmac_ctl_mask #(.NUM_CH(NUM_CH)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrst    (wr_stb.mrst),
        .mclr    (wr_stb.mclr),
        .mall    (wr_stb.mall),
        .smask   (wr_stb.smask),
        .sel     (sel),
        .flag    (flag),
        .all_val (wdata[NUM_CH-1:0]),
        .mask_q  (mask_q),
        .mask_d  (mask_d)
    );

    dmac_ctl_status #(.NUM_CH(NUM_CH)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrst     (wr_stb.mrst),
        .req_wr   (wr_stb.req),
        .sel      (sel),
        .flag     (flag),
        .rd_clr   (rd_status),
        .dreq_set (dreq_set),
        .dreq_clr (dreq_clr),
        .tc_in    (tc_in),
        .stat_q   (stat_q),
        .req_d    (req_d)
    );

    // Command filter: accept zero or values using only the permitted bit.
    assign cmd_ok = ((wdata & ~DATA_W'(CMD_ALLOWED)) == '0);

    // Command register: loaded by accepted writes, cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_stb.mrst)
            cmd_q <= '0;
        else if (wr_stb.cmd && cmd_ok)
            cmd_q <= wdata;
    end

    // Per-channel mode bytes, one register per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mode
        // Mode byte for this channel, loaded when the select matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_flat[ch*DATA_W +: DATA_W] <= '0;
            else if (wr_stb.mode && (sel == SEL_W'(ch)))
                mode_flat[ch*DATA_W +: DATA_W] <= wdata;
        end
    end

    // Service vector, registered from the next mask and request state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            svc_req <= '0;
        else
            svc_req <= ~mask_d & req_d;
    end

    // Byte-pointer clear pulse, one cycle after a clear or master reset write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_ptr <= 1'b0;
        else
            clr_ptr <= wr_stb.ptrclr || wr_stb.mrst;
    end

    // Host read mux: status, mask, or zero.
    always_comb begin
        rdata = '0;
        if (rd_status)
            rdata[ST_W-1:0] = stat_q;
        else if (rd_mask)
            rdata[NUM_CH-1:0] = mask_q;
    end

    // R2: the command register only ever holds a legal value.
    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q & ~DATA_W'(CMD_ALLOWED)) == '0));

    // R12: a masked channel is never offered for service.
    assert_svc_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc_req & mask_q) == '0));

    // R6: the pointer clear is a single-cycle pulse unless writes repeat.
    assert_ptr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ptr && !$past(wr_stb.ptrclr || wr_stb.mrst)) |-> 1'b0);

    // R9: nothing is returned without a read strobe.
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

endmodule

// File: tb/test_dmac_ctl_top.sv
module test_dmac_ctl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  dreq_set = '0;
    logic [3:0]  dreq_clr = '0;
    logic [3:0]  tc_in = '0;
    logic [3:0]  svc_req;
    logic        clr_ptr;
    logic [7:0]  cmd_q;
    logic [31:0] mode_flat;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] rd_sample;

    always #5 clk = ~clk;

    dmac_ctl_top i_dmac_ctl_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
        .wdata(wdata), .rdata(rdata), .dreq_set(dreq_set), .dreq_clr(dreq_clr),
        .tc_in(tc_in), .svc_req(svc_req), .clr_ptr(clr_ptr), .cmd_q(cmd_q),
        .mode_flat(mode_flat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, capture rdata before the rising edge,
    // then return strobes to idle just after the edge.
    task automatic step(input logic wr, input logic rd, input logic [3:0] ix,
                        input logic [7:0] wd, input logic [3:0] ds,
                        input logic [3:0] dc, input logic [3:0] tc);
        @(negedge clk);
        wr_en = wr; rd_en = rd; idx = ix; wdata = wd;
        dreq_set = ds; dreq_clr = dc; tc_in = tc;
        #1 rd_sample = rdata;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; idx = 0; wdata = 0;
        dreq_set = 0; dreq_clr = 0; tc_in = 0;
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] wd);
        step(1, 0, ix, wd, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic rd(input logic [3:0] ix);
        step(0, 1, ix, 8'h00, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic idle();
        step(0, 0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0);
    endtask

    typedef struct packed {
        logic       w;
        logic [3:0] ix;
        logic [7:0] wd;
        logic [3:0] ds;
        logic [3:0] dc;
        logic [3:0] exp_svc;
    } vec_t;

    // Starts from reset state: mask 1111, status 0.
    localparam vec_t TBL [0:11] = '{
        '{1'b0, 4'h0, 8'h00, 4'b0001, 4'b0000, 4'b0000}, // R10 request, still masked
        '{1'b1, 4'hE, 8'h00, 4'b0000, 4'b0000, 4'b0001}, // R8 clear all mask
        '{1'b0, 4'h0, 8'h00, 4'b0100, 4'b0000, 4'b0101}, // R10 second request
        '{1'b1, 4'hA, 8'h06, 4'b0000, 4'b0000, 4'b0001}, // R4 mask ch2
        '{1'b0, 4'h0, 8'h00, 4'b0000, 4'b0001, 4'b0000}, // R10 release ch0
        '{1'b1, 4'h9, 8'h07, 4'b0000, 4'b0000, 4'b1000}, // R3 soft request ch3
        '{1'b1, 4'hF, 8'h0A, 4'b0000, 4'b0000, 4'b0100}, // R8 load mask 1010
        '{1'b1, 4'h9, 8'h03, 4'b0000, 4'b0000, 4'b0100}, // R3 clear request ch3
        '{1'b1, 4'hA, 8'h01, 4'b0000, 4'b0000, 4'b0100}, // R4 unmask ch1
        '{1'b0, 4'h0, 8'h00, 4'b0010, 4'b0000, 4'b0110}, // R12 ch1 request
        '{1'b1, 4'hD, 8'h00, 4'b0000, 4'b0000, 4'b0000}, // R7 master reset
        '{1'b1, 4'hE, 8'h00, 4'b0000, 4'b0000, 4'b0000}  // R8 unmask, no requests
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 svc", svc_req, 0);
        chk("R1 clr_ptr", clr_ptr, 0);
        chk("R1 cmd", cmd_q, 0);
        chk("R1 mode", mode_flat, 0);
        rd(4'hF); chk("R1 mask", rd_sample, 8'h0F);
        rd(4'h8); chk("R1 status", rd_sample, 8'h00);

        // R12 table walk
        for (int i = 0; i < 12; i++) begin
            step(TBL[i].w, 1'b0, TBL[i].ix, TBL[i].wd, TBL[i].ds, TBL[i].dc, 4'h0);
            chk($sformatf("R12 table row %0d svc", i), svc_req, TBL[i].exp_svc);
        end

        // R11 / R9: terminal count then read and clear
        step(0, 0, 4'h0, 8'h00, 4'h0, 4'h0, 4'b0101);
        rd(4'h8); chk("R11 tc recorded", rd_sample, 8'h05);
        rd(4'h8); chk("R9 status read clears tc", rd_sample, 8'h00);
        step(0, 1, 4'h8, 8'h00, 4'h0, 4'h0, 4'b0010);
        chk("R9 read before tc", rd_sample, 8'h00);
        rd(4'h8); chk("R11 tc wins over read clear", rd_sample, 8'h02);
        rd(4'h8);

        // R3: request write clears that channel's tc
        step(0, 0, 4'h0, 8'h00, 4'h0, 4'h0, 4'b0010);
        wr(4'h9, 8'h05);
        chk("R3 svc after soft request", svc_req, 4'b0010);
        rd(4'h8); chk("R3 status after soft request", rd_sample, 8'h20);
        wr(4'h9, 8'h01);
        chk("R3 svc after soft clear", svc_req, 4'b0000);

        // R10: set wins over release in the same cycle
        step(0, 0, 4'h0, 8'h00, 4'b0001, 4'b0001, 4'h0);
        chk("R10 set wins", svc_req, 4'b0001);
        step(0, 0, 4'h0, 8'h00, 4'h0, 4'b0001, 4'h0);
        chk("R10 release", svc_req, 4'b0000);

        // R9: mask read and other indexes
        wr(4'hF, 8'hF5);
        rd(4'hF); chk("R9 mask read", rd_sample, 8'h05);
        rd(4'h9); chk("R9 index 9 reads zero", rd_sample, 8'h00);
        rd(4'h3); chk("R9 low index reads zero", rd_sample, 8'h00);

        // R2: command filter
        wr(4'h8, 8'h04); chk("R2 legal cmd", cmd_q, 8'h04);
        wr(4'h8, 8'h10); chk("R2 illegal cmd dropped", cmd_q, 8'h04);
        wr(4'h8, 8'h00); chk("R2 zero cmd", cmd_q, 8'h00);
        wr(4'h8, 8'h05); chk("R2 mixed cmd dropped", cmd_q, 8'h00);

        // R5: mode bytes
        wr(4'hB, 8'h96); chk("R5 mode ch2", mode_flat, 32'h0096_0000);
        wr(4'hB, 8'h4D); chk("R5 mode ch1 keeps ch2", mode_flat, 32'h0096_4D00);

        // R6: pointer clear pulse, no register change
        wr(4'hC, 8'h00); chk("R6 pulse high", clr_ptr, 1);
        idle();          chk("R6 pulse ends", clr_ptr, 0);
        rd(4'hF); chk("R6 mask untouched", rd_sample, 8'h05);

        // R13: low-index writes ignored
        wr(4'h8, 8'h04);
        wr(4'h3, 8'hFF); wr(4'h7, 8'h00);
        rd(4'hF); chk("R13 mask untouched", rd_sample, 8'h05);
        chk("R13 cmd untouched", cmd_q, 8'h04);
        chk("R13 mode untouched", mode_flat, 32'h0096_4D00);

        // R7: master reset with a same-cycle request
        wr(4'hE, 8'h00);
        step(1, 0, 4'hD, 8'h00, 4'b1000, 4'h0, 4'b0001);
        chk("R7 clr_ptr", clr_ptr, 1);
        chk("R7 cmd cleared", cmd_q, 0);
        chk("R7 svc cleared", svc_req, 0);
        chk("R7 mode kept", mode_flat, 32'h0096_4D00);
        rd(4'hF); chk("R7 mask all ones", rd_sample, 8'h0F);
        rd(4'h8); chk("R7 status zero", rd_sample, 8'h00);

        // R1: hardware reset mid-run
        wr(4'hE, 8'h00);
        step(0, 0, 4'h0, 8'h00, 4'b0011, 4'h0, 4'h0);
        chk("R12 before reset", svc_req, 4'b0011);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk("R1 svc after reset", svc_req, 0);
        chk("R1 mode after reset", mode_flat, 0);
        rd(4'hF); chk("R1 mask after reset", rd_sample, 8'h0F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule